// File: doc/BRIEF.md
# Program Status Word with Per-Mode Saved Copies

This block holds the processor's live status word and five saved copies of it, one per exception mode. Inside, the live word is a set of separate fields: four condition flags (negative, zero, carry, overflow), two interrupt masks (normal and fast), the instruction-set state bit and a 5-bit mode field. On a read these fields are packed into one 32-bit word, and on a full-word write they are unpacked from it. A write that carries an unknown mode code is refused for the mode field only, and the block raises an error.

A second port reads and writes the saved copy that belongs to the current mode. In the two modes that have no saved copy, the access is refused and reported. Single flags can also be set or cleared through a bit mask without rewriting the whole word. Exception entry and return sequencing belong to the surrounding pipeline.

Top module: `psr_bank_unit`

## Requirements
- R1: After reset the live word reads 0x000000D3: supervisor mode, both interrupt masks set, every other bit clear. `err_o` is low and every saved copy reads zero.
- R2: `cur_rd_data` packs N at bit 31, Z at bit 30, C at bit 29, V at bit 28, I at bit 7, F at bit 6 and T at bit 5, with the mode in bits 4:0. All other bits read as zero, whatever value was written to them.
- R3: A full-word write (`cur_wr_en`) loads every flag from its bit position and the mode from bits 4:0. The new value is visible from the next cycle.
- R4: Seven mode codes are legal: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. A full-word write with any other code still loads the flags, leaves the mode unchanged and raises an error.
- R5: In fast interrupt, interrupt, supervisor, abort or undefined mode, a saved-status write goes to that mode's own copy and a read returns it. The five copies are independent.
- R6: A saved-status read in user or system mode returns zero on `sav_rd_data` in the same cycle and raises an error.
- R7: A saved-status write in user or system mode changes no saved copy and raises an error.
- R8: A flag update loads each flag whose bit is set in `flag_we` from `flag_wd` and leaves the others unchanged. Both vectors use the order N=6, Z=5, C=4, V=3, I=2, F=1, T=0. If a full-word write happens in the same cycle, the full-word write wins.
- R9: `flags_o` shows the individual flags in the R8 bit order and always agrees with `cur_rd_data`.
- R10: An error is a one-cycle pulse on `err_o` in the cycle after the offending access. `err_o` is low after any cycle with no illegal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_wr_en | input | 1 | Full-word write of the live status word |
| cur_wr_data | input | 32 | Word to unpack into the live fields |
| cur_rd_data | output | 32 | Packed live status word |
| sav_rd_en | input | 1 | Saved-status read strobe |
| sav_wr_en | input | 1 | Saved-status write strobe |
| sav_wr_data | input | 32 | Word to store in the current mode's saved copy |
| sav_rd_data | output | 32 | Saved copy of the current mode, or zero |
| flag_we | input | 7 | Per-flag update mask (N..T) |
| flag_wd | input | 7 | Per-flag update values (N..T) |
| flags_o | output | 7 | Individual flags (N..T) |
| err_o | output | 1 | Illegal-access pulse |

## Verification
The assertions assume that every input is 0 or 1 (never X) once reset has been released, and that the strobes are held low whenever no access is under way. Otherwise an error pulse could not be traced back to a strobe in the previous cycle. The bench changes inputs only on falling edges and returns every strobe to zero after its access. It covers all seven legal mode codes and several illegal ones, so the mode-hold and bank-select checks see every decode outcome. Saved-status accesses are made in all seven modes, so both the refused path and the steered path are exercised.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int WORD_W    = 32;
  localparam int MODE_W    = 5;
  localparam int FLAG_W    = 7;
  localparam int NUM_BANKS = 5;

  // flag vector order: N Z C V I F T (bit 6 down to bit 0)
  localparam int FL_N = 6;
  localparam int FL_T = 0;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [FLAG_W-1:0] flags_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_FIQ = 5'b10001;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;
  localparam mode_t MODE_ABT = 5'b10111;
  localparam mode_t MODE_UND = 5'b11011;
  localparam mode_t MODE_SYS = 5'b11111;

  localparam flags_t FLAGS_RST = 7'b0000110;

  // mode owning saved copy k
  function automatic mode_t bank_mode(input int k);
    case (k)
      0:       return MODE_FIQ;
      1:       return MODE_IRQ;
      2:       return MODE_SVC;
      3:       return MODE_ABT;
      default: return MODE_UND;
    endcase
  endfunction

  function automatic word_t pack_word(input flags_t f, input mode_t m);
    word_t w;
    w        = '0;
    w[31:28] = f[6:3];
    w[7:5]   = f[2:0];
    w[4:0]   = m;
    return w;
  endfunction

  function automatic flags_t unpack_flags(input word_t w);
    return {w[31:28], w[7:5]};
  endfunction

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
#(
  parameter int NBANK = NUM_BANKS
) (
  input  mode_t            mode,
  output logic             legal,
  output logic             banked,
  output logic [NBANK-1:0] sel
);

  genvar k;
  generate
    for (k = 0; k < NBANK; k++) begin : g_sel
      assign sel[k] = (mode == bank_mode(k));
    end
  endgenerate

  assign banked = |sel;
  assign legal  = banked | (mode == MODE_USR) | (mode == MODE_SYS);

endmodule

// File: rtl/psr_cur_reg.sv
module psr_cur_reg
  import psr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  flags_t wr_flags,
  input  mode_t  wr_mode,
  input  logic   wr_mode_ok,
  input  flags_t flag_we,
  input  flags_t flag_wd,
  output flags_t flags_q,
  output mode_t  mode_q
);

  flags_t flags_d;
  mode_t  mode_d;
  logic   upd_en;

  assign upd_en = wr_en | (|flag_we);

  always_comb begin
    flags_d = flags_q;
    mode_d  = mode_q;
    if (wr_en) begin
      flags_d = wr_flags;
      if (wr_mode_ok) mode_d = wr_mode;
    end else begin
      flags_d = (flags_q & ~flag_we) | (flag_wd & flag_we);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RST;
      mode_q  <= MODE_SVC;
    end else if (upd_en) begin
      flags_q <= flags_d;
      mode_q  <= mode_d;
    end
  end

  // R4: the held mode is always one of the seven legal codes
  p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_USR) || (mode_q == MODE_FIQ) || (mode_q == MODE_IRQ) ||
    (mode_q == MODE_SVC) || (mode_q == MODE_ABT) || (mode_q == MODE_UND) ||
    (mode_q == MODE_SYS));

  // R8: masked-off flags are untouched when no full write is present
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (flag_we == '0)) |=> $stable(flags_q) && $stable(mode_q));

endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int NBANK = NUM_BANKS,
  parameter int DW    = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [NBANK-1:0] rd_sel,
  output logic [DW-1:0]    rd_data
);

  logic [NBANK-1:0][DW-1:0] bank_q;

  genvar k;
  generate
    for (k = 0; k < NBANK; k++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bank_q[k] <= '0;
        else if (wr_sel[k]) bank_q[k] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBANK; i++) begin
      rd_data = rd_data | (bank_q[i] & {DW{rd_sel[i]}});
    end
  end

  // R7: no selected copy means every copy keeps its value
  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(bank_q));

  // R5: at most one copy is written at a time
  p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));

endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
  import psr_pkg::*;
#(
  parameter int NBANK = NUM_BANKS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cur_wr_en,
  input  logic [31:0] cur_wr_data,
  output logic [31:0] cur_rd_data,
  input  logic        sav_rd_en,
  input  logic        sav_wr_en,
  input  logic [31:0] sav_wr_data,
  output logic [31:0] sav_rd_data,
  input  logic [6:0]  flag_we,
  input  logic [6:0]  flag_wd,
  output logic [6:0]  flags_o,
  output logic        err_o
);

  logic             rst_q;
  flags_t           flags_q;
  mode_t            mode_q;
  mode_t            wr_mode;
  logic             wr_legal;
  logic             wr_banked_unused;
  logic [NBANK-1:0] wr_sel_unused;
  logic             cur_legal_unused;
  logic             cur_banked;
  logic [NBANK-1:0] cur_sel;
  logic [NBANK-1:0] bank_wr_sel;
  logic [NBANK-1:0] bank_rd_sel;
  logic             err_d;
  logic             err_q;
  logic             unused_bits;

  assign unused_bits = ^cur_wr_data[27:8];
  assign wr_mode     = cur_wr_data[MODE_W-1:0];

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // decode for the incoming word's mode field
  psr_mode_decode #(.NBANK(NBANK)) u_wr_dec (
    .mode   (wr_mode),
    .legal  (wr_legal),
    .banked (wr_banked_unused),
    .sel    (wr_sel_unused)
  );

  // decode for the mode currently held
  psr_mode_decode #(.NBANK(NBANK)) u_cur_dec (
    .mode   (mode_q),
    .legal  (cur_legal_unused),
    .banked (cur_banked),
    .sel    (cur_sel)
  );

  psr_cur_reg u_cur (
    .clk        (clk),
    .rst_n      (rst_q),
    .wr_en      (cur_wr_en),
    .wr_flags   (unpack_flags(cur_wr_data)),
    .wr_mode    (wr_mode),
    .wr_mode_ok (wr_legal),
    .flag_we    (flag_we),
    .flag_wd    (flag_wd),
    .flags_q    (flags_q),
    .mode_q     (mode_q)
  );

  assign bank_wr_sel = cur_sel & {NBANK{sav_wr_en}};
  assign bank_rd_sel = cur_sel & {NBANK{sav_rd_en}};

  psr_saved_bank #(.NBANK(NBANK), .DW(WORD_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_sel  (bank_wr_sel),
    .wr_data (sav_wr_data),
    .rd_sel  (bank_rd_sel),
    .rd_data (sav_rd_data)
  );

  // error: bad mode code on a full write, or saved access without a copy
  always_comb begin
    err_d = 1'b0;
    if (cur_wr_en && !wr_legal)                   err_d = 1'b1;
    if ((sav_rd_en || sav_wr_en) && !cur_banked)  err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o       = err_q;
  assign flags_o     = flags_q;
  assign cur_rd_data = pack_word(flags_q, mode_q);

  // R4: a refused mode code leaves the mode field as it was
  p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (cur_wr_en && !wr_legal) |=> $stable(cur_rd_data[4:0]));

  // R3: a full write always lands its condition flags
  p_word_flags_r3: assert property (@(posedge clk) disable iff (!rst_q)
    cur_wr_en |=> (cur_rd_data[31:28] == $past(cur_wr_data[31:28])));

  // R6: no saved copy readable outside banked modes
  p_sav_zero_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (sav_rd_en && !cur_banked) |-> (sav_rd_data == '0));

  // R10: an error pulse always follows an access strobe
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_q)
    err_o |-> $past(cur_wr_en || sav_rd_en || sav_wr_en));

  // R5: the held mode selects at most one saved copy
  p_bank_onehot_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(cur_sel));

  // R9: flag outputs agree with the packed word
  p_flags_match_r9: assert property (@(posedge clk) disable iff (!rst_q)
    flags_o == {cur_rd_data[31:28], cur_rd_data[7:5]});

endmodule

// File: tb/psr_bank_unit_tb_top.sv
`timescale 1ns/1ps
module psr_bank_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cur_wr_en;
  logic [31:0] cur_wr_data;
  logic [31:0] cur_rd_data;
  logic        sav_rd_en;
  logic        sav_wr_en;
  logic [31:0] sav_wr_data;
  logic [31:0] sav_rd_data;
  logic [6:0]  flag_we;
  logic [6:0]  flag_wd;
  logic [6:0]  flags_o;
  logic        err_o;

  int n_cmp;
  int n_bad;

  psr_bank_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_wr_en   (cur_wr_en),
    .cur_wr_data (cur_wr_data),
    .cur_rd_data (cur_rd_data),
    .sav_rd_en   (sav_rd_en),
    .sav_wr_en   (sav_wr_en),
    .sav_wr_data (sav_wr_data),
    .sav_rd_data (sav_rd_data),
    .flag_we     (flag_we),
    .flag_wd     (flag_wd),
    .flags_o     (flags_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // scoreboard item: kind 0 live word, 1 saved read, 2 error, 3 flags
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];

  // reference model
  logic [6:0]  m_flags;
  logic [4:0]  m_mode;
  logic [31:0] m_bank [5];

  function automatic logic [31:0] m_pack();
    return {m_flags[6:3], 20'h0, m_flags[2:0], m_mode};
  endfunction

  function automatic bit m_legal(input logic [4:0] m);
    return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
  endfunction

  function automatic int m_bidx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.req  = req;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    wait (sb_q.size() == 0);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      case (it.kind)
        0:       got = cur_rd_data;
        1:       got = sav_rd_data;
        2:       got = {31'b0, err_o};
        default: got = {25'b0, flags_o};
      endcase
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic cur_write(input logic [31:0] w, input string req);
    cur_wr_en   = 1'b1;
    cur_wr_data = w;
    @(posedge clk);
    m_flags = {w[31:28], w[7:5]};
    if (m_legal(w[4:0])) m_mode = w[4:0];
    @(negedge clk);
    cur_wr_en = 1'b0;
    push(0, m_pack(), req);
    push(2, {31'b0, !m_legal(w[4:0])}, req);
    push(3, {25'b0, m_flags}, "R9");
    settle();
  endtask

  task automatic sav_write(input logic [31:0] w, input string req);
    int b;
    b = m_bidx(m_mode);
    sav_wr_en   = 1'b1;
    sav_wr_data = w;
    @(posedge clk);
    if (b >= 0) m_bank[b] = w;
    @(negedge clk);
    sav_wr_en = 1'b0;
    push(2, {31'b0, b < 0}, req);
    settle();
  endtask

  task automatic sav_read(input string req);
    int b;
    b = m_bidx(m_mode);
    sav_rd_en = 1'b1;
    #1;
    push(1, (b >= 0) ? m_bank[b] : 32'h0, req);
    settle();
    @(posedge clk);
    @(negedge clk);
    sav_rd_en = 1'b0;
    push(2, {31'b0, b < 0}, req);
    settle();
  endtask

  task automatic flag_update(input logic [6:0] we, input logic [6:0] wd, input string req);
    flag_we = we;
    flag_wd = wd;
    @(posedge clk);
    m_flags = (m_flags & ~we) | (wd & we);
    @(negedge clk);
    flag_we = '0;
    flag_wd = '0;
    push(3, {25'b0, m_flags}, req);
    push(0, m_pack(), req);
    push(2, 32'h0, req);
    settle();
  endtask

  task automatic idle_err_low(input string req);
    @(posedge clk);
    @(negedge clk);
    push(2, 32'h0, req);
    settle();
  endtask

  // switch mode keeping current flags
  task automatic go_mode(input logic [4:0] m, input string req);
    cur_write({m_flags[6:3], 20'h0, m_flags[2:0], m}, req);
  endtask

  bit done;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] legal_codes [7];
    logic [4:0] bad_codes [3];
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    legal_codes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    bad_codes   = '{5'b00000, 5'b10100, 5'b11110};
    rst_n       = 1'b0;
    cur_wr_en   = 1'b0;
    cur_wr_data = '0;
    sav_rd_en   = 1'b0;
    sav_wr_en   = 1'b0;
    sav_wr_data = '0;
    flag_we     = '0;
    flag_wd     = '0;
    m_flags     = 7'b0000110;
    m_mode      = 5'b10011;
    for (int i = 0; i < 5; i++) m_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    push(0, 32'h0000_00D3, "R1");
    push(2, 32'h0, "R1");
    push(3, 32'h0000_0006, "R1");
    settle();
    sav_read("R1");

    // R2 / R3: pack and unpack, stray middle bits dropped
    cur_write(32'hA0FF_00F1, "R2");
    cur_write(32'h5000_0012, "R3");
    cur_write(32'hF000_00D3, "R3");

    // R5: each banked mode writes its own copy
    go_mode(5'b10001, "R5"); sav_write(32'h1111_1111, "R5");
    go_mode(5'b10010, "R5"); sav_write(32'h2222_2222, "R5");
    go_mode(5'b10011, "R5"); sav_write(32'h3333_3333, "R5");
    go_mode(5'b10111, "R5"); sav_write(32'h4444_4444, "R5");
    go_mode(5'b11011, "R5"); sav_write(32'h5555_5555, "R5");

    // R6 / R7: user and system refuse saved access
    go_mode(5'b10000, "R6");
    sav_read("R6");
    sav_write(32'hDEAD_BEEF, "R7");
    go_mode(5'b11111, "R6");
    sav_read("R6");
    sav_write(32'hCAFE_F00D, "R7");

    // R5 / R7: read every copy back, none disturbed
    go_mode(5'b10001, "R5"); sav_read("R5");
    go_mode(5'b10010, "R5"); sav_read("R5");
    go_mode(5'b10011, "R5"); sav_read("R5");
    go_mode(5'b10111, "R7"); sav_read("R7");
    go_mode(5'b11011, "R7"); sav_read("R7");

    // R4: every legal code accepted
    foreach (legal_codes[i]) cur_write({4'h3, 20'h0, 3'b010, legal_codes[i]}, "R4");

    // R4 / R10: illegal codes keep mode, load flags, pulse error once
    foreach (bad_codes[i]) begin
      cur_write({4'hF, 20'h0, 3'b101, bad_codes[i]}, "R4");
      idle_err_low("R10");
    end

    // R8: masked flag updates
    flag_update(7'b1000001, 7'b1111111, "R8");
    flag_update(7'b0110110, 7'b0100100, "R8");
    flag_update(7'b1111111, 7'b0000000, "R8");

    // R8: full write wins over flag update in the same cycle
    flag_we = 7'b1111111;
    flag_wd = 7'b1111111;
    cur_write(32'h0000_0013, "R8");
    flag_we = '0;
    flag_wd = '0;
    idle_err_low("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule